// File: doc/BRIEF.md
# Part-Number String Decoder

This block builds the identification string of a board from words kept in a word-addressed non-volatile memory. On a `start` pulse it reads two header words from fixed offsets through a one-request-at-a-time read port. If the first header word differs from a guard value, the two words hold a packed part number. The block then emits an 11-byte ASCII rendering of it. If the first word equals the guard, the second word points to a string section. That section begins with a length word, and the block copies the section out byte by byte.

Bytes leave the block one per `out_valid` pulse, each with its index. Each byte is a registered output. A run always ends with a one-cycle `done` pulse and a status code. The requester supplies the capacity of its buffer with `start`. A run whose result would not fit is refused before any byte is emitted.

Top module: `pn_string_decoder`

## Requirements
- R1: A run first reads the word at header offset HDR0, then the word at HDR1 (default 8 and 9). Each read is a single-cycle `rd_req` pulse, and the block issues no new request until `rd_ack` returns.
- R2: When the HDR0 word differs from GUARD (default 16'hFAFA), the legacy form is used. If the capacity is below 11, the run ends with status 1 (no space) and emits no byte.
- R3: The legacy form emits 11 bytes with indices 0 to 10, in this order. Indices 0-3 hold the HDR0 word's nibbles from bits 15:12 down to 3:0. Indices 4-5 hold the HDR1 word's bits 15:12 and 11:8. Index 6 is a hyphen (8'h2D). Index 7 is the character '0'. Indices 8-9 hold the HDR1 word's bits 7:4 and 3:0. Index 10 is 8'h00.
- R4: A nibble v below 10 becomes 8'h30+v, and a nibble from 10 to 15 becomes 8'h41+(v-10), which gives upper-case A-F.
- R5: When the HDR0 word equals GUARD, the HDR1 word is an address, and the length word is read there. A length of 16'h0000 or 16'hFFFF ends the run with status 2 (bad section) and no byte.
- R6: In the pointer form, a capacity below 2*length-1 ends the run with status 1 and no byte. A capacity exactly equal to it is accepted.
- R7: The pointer form copies the length-1 words at the addresses that follow the length word, in order. It emits bit 15:8 and then bit 7:0 of each word, and then a final 8'h00. A length of 1 gives only the null byte.
- R8: A read answered with `rd_err` ends the run with status 3 (read error). Bytes already emitted stay emitted, and no further byte follows.
- R9: After reset, `busy`, `rd_req`, `out_valid` and `done` are low. Indices of a run start at 0 and rise by one per byte. Each run ends with exactly one single-cycle `done` pulse, which carries the status and comes after the last byte. Status 0 means success.
- R10: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| cap | input | CAP_W | Requester buffer capacity in bytes, sampled at start |
| busy | output | 1 | Run in progress |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Word address of the request |
| rd_ack | input | 1 | Read response strobe |
| rd_data | input | 16 | Read response word |
| rd_err | input | 1 | Response carries an error |
| out_valid | output | 1 | Output byte strobe |
| out_idx | output | IDX_W | Index of the output byte |
| out_byte | output | 8 | Output byte |
| done | output | 1 | End-of-run pulse |
| status | output | 2 | 0 ok, 1 no space, 2 bad section, 3 read error; valid with done |

## Verification
The bench aims at the capacity boundaries. It runs capacities of exactly 11 and exactly 2*length-1 against one byte fewer. A design with an off-by-one comparison either refuses a buffer that fits or streams bytes into one that does not. Nibbles on both sides of 9/10 show whether the hex conversion lands on ':' instead of 'A'. The index 7 slot shows whether it was left as a raw zero instead of '0'. The lengths 0, 1 and 16'hFFFF, read errors in the middle of a copy and on the very first header read, and a stray start during a run show whether the design loops, skips the terminating null, keeps emitting after an error, or restarts partway through.

// File: rtl/pn_pkg.sv
package pn_pkg;

  typedef enum logic [1:0] {
    PN_OK      = 2'd0,
    PN_NOSPACE = 2'd1,
    PN_SECTION = 2'd2,
    PN_RDERR   = 2'd3
  } pn_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_LEGACY,
    S_STR_HI,
    S_STR_LO,
    S_NULL,
    S_DONE
  } pn_state_e;

  typedef enum logic [1:0] {
    PH_H0,
    PH_H1,
    PH_LEN,
    PH_DATA
  } pn_phase_e;

  localparam int LEG_BYTES = 11;
  localparam int LEG_HYPHEN_IDX = 6;
  localparam logic [7:0] HYPHEN_CH = 8'h2D;

endpackage

// File: rtl/pn_hexchar.sv
module pn_hexchar (
  input  logic [3:0] nib,
  output logic [7:0] ch
);
  always_comb begin
    if (nib < 4'd10) ch = 8'h30 + {4'h0, nib};
    else             ch = 8'h37 + {4'h0, nib};
  end
endmodule

// File: rtl/pn_legacy_mux.sv
module pn_legacy_mux
  import pn_pkg::*;
(
  input  logic [15:0] w0,
  input  logic [15:0] w1,
  input  logic [3:0]  sel,
  output logic [7:0]  byte_o
);
  localparam int NSLOT = 16;
  localparam int NHEX  = LEG_BYTES - 1;

  // slot g takes nibble nib_vec[4g+:4]; slot 7 is a zero nibble, slot 6 is overridden
  logic [4*NHEX-1:0] nib_vec;
  logic [7:0] chars [NSLOT];

  assign nib_vec = {w1[3:0], w1[7:4], 4'h0, 4'h0, w1[11:8], w1[15:12],
                    w0[3:0], w0[7:4], w0[11:8], w0[15:12]};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NHEX) begin : g_hex
      pn_hexchar u_hex (
        .nib (nib_vec[4*g +: 4]),
        .ch  (chars[g])
      );
    end else begin : g_nul
      assign chars[g] = 8'h00;
    end
  end

  assign byte_o = (sel == 4'(LEG_HYPHEN_IDX)) ? HYPHEN_CH : chars[sel];
endmodule

// File: rtl/pn_len_check.sv
module pn_len_check #(
  parameter int LEN_W = 16,
  parameter int CAP_W = 16
) (
  input  logic             legacy_mode,
  input  logic [LEN_W-1:0] len,
  input  logic [CAP_W-1:0] cap,
  output logic             bad_len,
  output logic             short_cap
);
  import pn_pkg::*;
  localparam int NW = LEN_W + 2;
  localparam int MW = (CAP_W > NW) ? CAP_W : NW;

  logic [MW-1:0] need;
  logic [MW-1:0] cap_ext;

  always_comb begin
    if (legacy_mode) need = MW'(LEG_BYTES);
    else             need = (MW'(len) << 1) - MW'(1);
  end

  assign cap_ext   = MW'(cap);
  assign bad_len   = (len == '0) || (&len);
  assign short_cap = cap_ext < need;
endmodule

// File: rtl/pn_string_decoder.sv
module pn_string_decoder
  import pn_pkg::*;
#(
  parameter int          AW    = 16,
  parameter int          CAP_W = 16,
  parameter int          IDX_W = 17,
  parameter int          HDR0  = 8,
  parameter int          HDR1  = 9,
  parameter logic [15:0] GUARD = 16'hFAFA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CAP_W-1:0] cap,
  output logic             busy,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [15:0]      rd_data,
  input  logic             rd_err,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [7:0]       out_byte,
  output logic             done,
  output logic [1:0]       status
);
  localparam logic [IDX_W-1:0] LEG_LAST = IDX_W'(LEG_BYTES - 1);

  pn_state_e        state_q;
  pn_phase_e        phase_q;
  pn_status_e       status_q;
  logic [AW-1:0]    addr_q;
  logic [15:0]      w0_q;
  logic [15:0]      w1_q;
  logic [15:0]      remain_q;
  logic [IDX_W-1:0] idx_q;
  logic [CAP_W-1:0] cap_q;
  logic             legacy_q;

  logic [7:0] leg_byte;
  logic       bad_len;
  logic       short_cap;

  pn_legacy_mux u_leg (
    .w0     (w0_q),
    .w1     (w1_q),
    .sel    (idx_q[3:0]),
    .byte_o (leg_byte)
  );

  pn_len_check #(.LEN_W(16), .CAP_W(CAP_W)) u_len (
    .legacy_mode (phase_q == PH_H1),
    .len         (rd_data),
    .cap         (cap_q),
    .bad_len     (bad_len),
    .short_cap   (short_cap)
  );

  assign busy   = (state_q != S_IDLE);
  assign status = status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      phase_q   <= PH_H0;
      status_q  <= PN_OK;
      addr_q    <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      remain_q  <= '0;
      idx_q     <= '0;
      cap_q     <= '0;
      legacy_q  <= 1'b0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_byte  <= '0;
      done      <= 1'b0;
    end else begin
      rd_req    <= 1'b0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            addr_q   <= AW'(HDR0);
            phase_q  <= PH_H0;
            idx_q    <= '0;
            cap_q    <= cap;
            legacy_q <= 1'b0;
            state_q  <= S_REQ;
          end
        end
        S_REQ: begin
          rd_req  <= 1'b1;
          rd_addr <= addr_q;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (rd_ack) begin
            if (rd_err) begin
              status_q <= PN_RDERR;
              state_q  <= S_DONE;
            end else begin
              case (phase_q)
                PH_H0: begin
                  w0_q    <= rd_data;
                  addr_q  <= AW'(HDR1);
                  phase_q <= PH_H1;
                  state_q <= S_REQ;
                end
                PH_H1: begin
                  w1_q <= rd_data;
                  if (w0_q != GUARD) begin
                    legacy_q <= 1'b1;
                    if (short_cap) begin
                      status_q <= PN_NOSPACE;
                      state_q  <= S_DONE;
                    end else begin
                      state_q <= S_LEGACY;
                    end
                  end else begin
                    addr_q  <= AW'(rd_data);
                    phase_q <= PH_LEN;
                    state_q <= S_REQ;
                  end
                end
                PH_LEN: begin
                  if (bad_len) begin
                    status_q <= PN_SECTION;
                    state_q  <= S_DONE;
                  end else if (short_cap) begin
                    status_q <= PN_NOSPACE;
                    state_q  <= S_DONE;
                  end else begin
                    remain_q <= rd_data - 16'd1;
                    addr_q   <= addr_q + AW'(1);
                    phase_q  <= PH_DATA;
                    state_q  <= (rd_data == 16'd1) ? S_NULL : S_REQ;
                  end
                end
                default: begin
                  w1_q    <= rd_data;
                  state_q <= S_STR_HI;
                end
              endcase
            end
          end
        end
        S_LEGACY: begin
          out_valid <= 1'b1;
          out_idx   <= idx_q;
          out_byte  <= leg_byte;
          idx_q     <= idx_q + IDX_W'(1);
          if (idx_q == LEG_LAST) begin
            status_q <= PN_OK;
            state_q  <= S_DONE;
          end
        end
        S_STR_HI: begin
          out_valid <= 1'b1;
          out_idx   <= idx_q;
          out_byte  <= w1_q[15:8];
          idx_q     <= idx_q + IDX_W'(1);
          state_q   <= S_STR_LO;
        end
        S_STR_LO: begin
          out_valid <= 1'b1;
          out_idx   <= idx_q;
          out_byte  <= w1_q[7:0];
          idx_q     <= idx_q + IDX_W'(1);
          remain_q  <= remain_q - 16'd1;
          if (remain_q == 16'd1) begin
            state_q <= S_NULL;
          end else begin
            addr_q  <= addr_q + AW'(1);
            state_q <= S_REQ;
          end
        end
        S_NULL: begin
          out_valid <= 1'b1;
          out_idx   <= idx_q;
          out_byte  <= 8'h00;
          status_q  <= PN_OK;
          state_q   <= S_DONE;
        end
        default: begin
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R1
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy); // R1
  AST_LEG_HYPHEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && legacy_q && out_idx == IDX_W'(LEG_HYPHEN_IDX)) |-> out_byte == HYPHEN_CH); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> out_idx == $past(out_idx) + IDX_W'(1)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid); // R8

endmodule

// File: tb/tb_pn_string_decoder.sv
`timescale 1ns/1ps
module tb_pn_string_decoder;
  localparam int          AW    = 16;
  localparam int          CAP_W = 16;
  localparam int          IDX_W = 17;
  localparam int          HDR0  = 8;
  localparam int          HDR1  = 9;
  localparam logic [15:0] GUARD = 16'hFAFA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CAP_W-1:0] cap = '0;
  logic busy, rd_req, rd_ack, rd_err, out_valid, done;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data;
  logic [IDX_W-1:0] out_idx;
  logic [7:0] out_byte;
  logic [1:0] status;

  always #2.5 clk = ~clk;

  pn_string_decoder #(.AW(AW), .CAP_W(CAP_W), .IDX_W(IDX_W),
                      .HDR0(HDR0), .HDR1(HDR1), .GUARD(GUARD)) dut (
    .clk(clk), .rst(rst), .start(start), .cap(cap), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .out_valid(out_valid), .out_idx(out_idx),
    .out_byte(out_byte), .done(done), .status(status));

  logic [15:0] mem [1024];
  int lat = 1;
  bit err_en = 0;
  int err_addr = 0;
  int got_addrs[$];
  int exp_addrs[$];
  int exp_bytes[$];
  int exp_status;
  int pos;
  int done_cnt;
  string cur_req = "R3";
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int hexc(input int n);
    return (n < 10) ? 48 + n : 55 + n;
  endfunction

  // memory model: one outstanding request, response after lat cycles
  initial begin
    rd_ack = 1'b0; rd_data = '0; rd_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        int a;
        a = int'(rd_addr);
        got_addrs.push_back(a);
        repeat (lat - 1) @(negedge clk);
        rd_ack  = 1'b1;
        rd_data = mem[a % 1024];
        rd_err  = err_en && (a == err_addr);
        @(negedge clk);
        rd_ack = 1'b0;
        rd_err = 1'b0;
      end
    end
  end

  // per-clock comparison of the byte stream against the reference queue
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (pos >= exp_bytes.size()) begin
          chk(1'b0, cur_req, "unexpected byte", int'(out_byte), -1);
        end else begin
          chk(int'(out_byte) == exp_bytes[pos], cur_req, "byte value",
              int'(out_byte), exp_bytes[pos]);
          chk(int'(out_idx) == pos, "R9", "byte index", int'(out_idx), pos);
        end
        pos++;
      end
      if (done) done_cnt++;
    end
  end

  // behavioural reference: expected reads, bytes and status
  task automatic build_ref(input int capv);
    int w0, w1, len, p, w;
    exp_addrs.delete(); exp_bytes.delete();
    exp_addrs.push_back(HDR0);
    if (err_en && err_addr == HDR0) begin exp_status = 3; return; end
    w0 = int'(mem[HDR0]);
    exp_addrs.push_back(HDR1);
    if (err_en && err_addr == HDR1) begin exp_status = 3; return; end
    w1 = int'(mem[HDR1]);
    if (w0 != int'(GUARD)) begin
      if (capv < 11) begin exp_status = 1; return; end
      exp_bytes.push_back(hexc((w0 >> 12) & 15));
      exp_bytes.push_back(hexc((w0 >> 8) & 15));
      exp_bytes.push_back(hexc((w0 >> 4) & 15));
      exp_bytes.push_back(hexc(w0 & 15));
      exp_bytes.push_back(hexc((w1 >> 12) & 15));
      exp_bytes.push_back(hexc((w1 >> 8) & 15));
      exp_bytes.push_back(45);
      exp_bytes.push_back(48);
      exp_bytes.push_back(hexc((w1 >> 4) & 15));
      exp_bytes.push_back(hexc(w1 & 15));
      exp_bytes.push_back(0);
      exp_status = 0;
      return;
    end
    p = w1;
    exp_addrs.push_back(p);
    if (err_en && err_addr == p) begin exp_status = 3; return; end
    len = int'(mem[p % 1024]);
    if (len == 0 || len == 65535) begin exp_status = 2; return; end
    if (capv < 2 * len - 1) begin exp_status = 1; return; end
    for (int k = 1; k < len; k++) begin
      exp_addrs.push_back(p + k);
      if (err_en && err_addr == p + k) begin exp_status = 3; return; end
      w = int'(mem[(p + k) % 1024]);
      exp_bytes.push_back((w >> 8) & 255);
      exp_bytes.push_back(w & 255);
    end
    exp_bytes.push_back(0);
    exp_status = 0;
  endtask

  task automatic run(input int capv, input int latv, input bit extra,
                     input string breq, input string sreq);
    int cyc;
    bit seen;
    lat = latv;
    build_ref(capv);
    got_addrs.delete();
    pos = 0; done_cnt = 0; cur_req = breq;
    @(negedge clk);
    cap = CAP_W'(capv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; seen = 0;
    while (cyc < 5000 && !seen) begin
      @(negedge clk);
      cyc++;
      if (extra && cyc == 6) start = 1'b1;
      else start = 1'b0;
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(seen, sreq, "run reached done", int'(seen), 1);
    chk(int'(status) == exp_status, sreq, "status", int'(status), exp_status);
    repeat (3) @(negedge clk);
    chk(pos == exp_bytes.size(), breq, "byte count", pos, exp_bytes.size());
    chk(got_addrs.size() == exp_addrs.size(), "R1", "read count",
        got_addrs.size(), exp_addrs.size());
    for (int i = 0; i < exp_addrs.size() && i < got_addrs.size(); i++)
      chk(got_addrs[i] == exp_addrs[i], "R1", "read address", got_addrs[i], exp_addrs[i]);
    chk(done_cnt == 1, extra ? "R10" : "R9", "done pulses", done_cnt, 1);
    chk(!busy, "R9", "idle after run", int'(busy), 0);
  endtask

  task automatic set_ptr_section();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[HDR0] = GUARD;
    mem[HDR1] = 16'h0040;
    mem[16'h40] = 16'd4;
    mem[16'h41] = 16'h4142;
    mem[16'h42] = 16'h4344;
    mem[16'h43] = 16'h4546;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    chk(!busy && !rd_req && !out_valid && !done, "R9", "reset outputs",
        {28'd0, busy, rd_req, out_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_req && !out_valid && !done, "R9", "idle after reset",
        {28'd0, busy, rd_req, out_valid, done}, 0);

    // legacy form, capacity exactly 11
    mem[HDR0] = 16'h1A3F; mem[HDR1] = 16'hB07C;
    run(11, 1, 0, "R3", "R2");
    // legacy form, one byte short
    run(10, 2, 0, "R2", "R2");
    // legacy form, all nibble classes around 9/10
    mem[HDR0] = 16'h9E05; mem[HDR1] = 16'hD2F8;
    run(40, 3, 0, "R4", "R2");
    mem[HDR0] = 16'hA09F; mem[HDR1] = 16'h0000;
    run(11, 1, 0, "R4", "R2");

    // pointer form, capacity exactly 2*len-1
    set_ptr_section();
    run(7, 1, 0, "R7", "R6");
    run(6, 2, 0, "R6", "R6");
    // bad lengths
    mem[16'h40] = 16'h0000;
    run(100, 1, 0, "R5", "R5");
    mem[16'h40] = 16'hFFFF;
    run(100, 2, 0, "R5", "R5");
    // length 1: only the null byte
    mem[16'h40] = 16'd1;
    run(1, 1, 0, "R7", "R7");
    // mixed byte values
    mem[16'h40] = 16'd3; mem[16'h41] = 16'h00FF; mem[16'h42] = 16'hFF00;
    run(100, 2, 0, "R7", "R7");

    // read error during the copy, then on the first header read
    set_ptr_section();
    err_en = 1; err_addr = 16'h42;
    run(100, 1, 0, "R8", "R8");
    err_addr = HDR0;
    run(100, 2, 0, "R8", "R8");
    err_en = 0;

    // start while busy
    run(7, 2, 1, "R10", "R10");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule